// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block turns a fast core clock into the serial clock of a synchronous serial master. It also produces two one-cycle strobes that a shift engine can use to launch and capture data. An 8-bit configuration byte sets the division ratio. The byte is read in one of two formats, chosen by a mode input.

In the wide format, a 4-bit scaler is multiplied by a power-of-two pre-scaler. The 3-bit exponent of the pre-scaler is spread over two separate places in the byte. This gives any divisor of the form scaler x 2^k, from 1 up to 1920. In the narrow format, only even divisors from 4 to 30 can be set.

The divisor is captured at the start of every serial clock period, so a new setting never cuts a period short. While the run input is low, the clock rests low and the counter is cleared.

Top module: `sclk_prescaler`

## Requirements
- R1: With `wide_mode`=1, the divisor is `cfg[3:0]` x 2^E, where E = {`cfg[7]`,`cfg[6]`,`cfg[4]`} (`cfg[7]` is the MSB). The spacing between successive `lead_stb` pulses equals this divisor in core cycles.
- R2: With `wide_mode`=0, a setting is legal when `cfg[4]`=1 and `cfg[3:0]` is between 2 and 15. The divisor is then 2 x `cfg[3:0]` (4 to 30), and bits 7:5 have no effect.
- R3: An illegal setting produces no strobes and keeps `sclk` low. In the wide format this means `cfg[3:0]`=0. In the narrow format it means `cfg[4]`=0 or `cfg[3:0]`<2.
- R4: `cfg[5]` has no effect on the divisor in either format.
- R5: For a divisor D>=2, `sclk` is high for floor(D/2) cycles at the start of each period and low for the rest of the period.
- R6: For D=1, `sclk` follows the core clock while running: high in the clock's high half and low in its low half. Both strobes are asserted on every cycle.
- R7: A configuration change made during a period takes effect only at the next period boundary. The period already in progress completes with the old divisor.
- R8: After reset, and in the cycle after `run` goes low, `sclk`, `lead_stb` and `trail_stb` are all 0. After `run` rises with a legal setting, `lead_stb` is asserted in the next cycle.
- R9: `lead_stb` marks the first high cycle of `sclk`. `trail_stb` marks the first low cycle of `sclk`, floor(D/2) cycles after `lead_stb`. For D>=2, each strobe is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 8 | Divider configuration byte |
| wide_mode | input | 1 | 1 selects the wide format, 0 the narrow even-only format |
| run | input | 1 | Enables the serial clock |
| sclk | output | 1 | Serial clock, idle low |
| lead_stb | output | 1 | One-cycle strobe on the cycle `sclk` rises |
| trail_stb | output | 1 | One-cycle strobe on the cycle `sclk` falls |

## Verification
The period boundary and a configuration write can fall in the same cycle, because the divisor is reloaded there. The bench changes `cfg` exactly on a `lead_stb` cycle. It then expects the old spacing for one more period and the new spacing afterwards.

With a divisor of 1, the rising and falling strobes coincide on every cycle. The bench drives this case and expects both strobes together on each cycle. It also checks that `sclk` tracks the core clock phase.

// File: rtl/sclk_prescaler.sv
`timescale 1ns/1ps
module sclk_prescaler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic       wide_mode,
  input  logic       run,
  output logic       sclk,
  output logic       lead_stb,
  output logic       trail_stb
);
  localparam int SCL_W   = 4;
  localparam int EXP_MAX = 7;
  localparam int DIV_W   = SCL_W + EXP_MAX;

  logic [SCL_W-1:0] scaler;
  logic [2:0]       expo;
  logic [DIV_W-1:0] div_wide, div_narrow, div_new;
  logic             cfg_ok;

  assign scaler     = cfg[3:0];
  assign expo       = {cfg[7:6], cfg[4]};
  assign div_wide   = DIV_W'(scaler) << expo;
  assign div_narrow = DIV_W'({cfg[3:0], 1'b0});
  assign div_new    = wide_mode ? div_wide : div_narrow;
  assign cfg_ok     = wide_mode ? (scaler != '0) : (cfg[4] && cfg[3:1] != 3'd0);

  logic             active;
  logic [DIV_W-1:0] div_q, cnt, half_q;
  logic             div_one, at_end;

  assign half_q  = div_q >> 1;
  assign div_one = (div_q == DIV_W'(1));
  assign at_end  = (cnt == div_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      div_q  <= DIV_W'(1);
    end else if (!run) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (at_end) begin
        cnt <= '0;
        if (cfg_ok) div_q <= div_new;
        else        active <= 1'b0;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end else if (cfg_ok) begin
      active <= 1'b1;
      cnt    <= '0;
      div_q  <= div_new;
    end
  end

  assign sclk      = active && (div_one ? clk : (cnt < half_q));
  assign lead_stb  = active && (cnt == '0);
  assign trail_stb = active && (cnt == half_q);

  a_r8_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lead_stb && !trail_stb && !active));
  a_r3_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (div_q != '0));
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < div_q));
  a_r7_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0) |-> $stable(div_q));
  a_r9_lead_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb && !div_one) |=> !lead_stb);
endmodule

// File: tb/sclk_prescaler_tb.sv
`timescale 1ns/1ps
module sclk_prescaler_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic wide_mode = 1'b1, run = 1'b0;
  logic sclk, lead_stb, trail_stb;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  sclk_prescaler u_dut (.clk(clk), .rst_n(rst_n), .cfg(cfg), .wide_mode(wide_mode),
                        .run(run), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input bit m, input logic [7:0] c);
    run = 1'b0;
    @(negedge clk); @(negedge clk);
    cfg = c; wide_mode = m; run = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure(input bit m, input logic [7:0] c, input int d, input string req);
    int highs = 0, tr = -1, nxt = -1;
    start(m, c);
    if (d == 0) begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (lead_stb || trail_stb || sclk) seen++;
        @(negedge clk);
      end
      check(seen == 0, {req, " R3 illegal setting idle"}, seen, 0);
      return;
    end
    check(lead_stb == 1'b1, {req, " R8 first lead latency"}, lead_stb, 1);
    for (int t = 0; t < 3 * d + 8; t++) begin
      if (t > 0 && lead_stb) begin nxt = t; break; end
      if (sclk) highs++;
      if (trail_stb && tr < 0) tr = t;
      @(negedge clk);
    end
    check(nxt == d, {req, " period"}, nxt, d);
    check(highs == ((d == 1) ? 0 : d / 2), {req, " R5 high phase"}, highs, d / 2);
    check(tr == d / 2, {req, " R9 trail position"}, tr, d / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R8 reset state", {sclk, lead_stb, trail_stb}, 0);
    rst_n = 1'b1;

    for (int e = 0; e < 8; e++)
      for (int s = 1; s < 16; s++)
        measure(1'b1, {e[2:1], 1'b0, e[0], s[3:0]}, s << e, "R1 wide");

    for (int h = 2; h < 16; h++)
      measure(1'b0, {3'b000, 1'b1, h[3:0]}, 2 * h, "R2 narrow");
    measure(1'b0, 8'hF3, 6, "R2 narrow upper bits ignored");

    measure(1'b1, 8'h38, 16, "R4 bit5 wide");
    measure(1'b0, 8'h37, 14, "R4 bit5 narrow");

    measure(1'b1, 8'h00, 0, "R3 wide scaler0");
    measure(1'b1, 8'hD0, 0, "R3 wide scaler0 exp7");
    measure(1'b0, 8'h0A, 0, "R3 narrow bit4 clear");
    measure(1'b0, 8'h11, 0, "R3 narrow divisor2");
    measure(1'b0, 8'h10, 0, "R3 narrow divisor0");

    start(1'b1, 8'h01);
    for (int i = 0; i < 6; i++) begin
      check(lead_stb && trail_stb, "R6 both strobes each cycle", {lead_stb, trail_stb}, 3);
      check(!sclk, "R6 sclk low in clock low half", sclk, 0);
      @(posedge clk); #1;
      check(sclk, "R6 sclk high in clock high half", sclk, 1);
      @(negedge clk);
    end

    start(1'b1, 8'h18);
    check(lead_stb, "R7 start lead", lead_stb, 1);
    cfg = 8'h04;
    gap = 0;
    for (int t = 1; t < 40; t++) begin
      @(negedge clk);
      if (lead_stb) begin gap = t; break; end
    end
    check(gap == 16, "R7 old divisor finishes", gap, 16);
    gap = 0;
    for (int t = 1; t < 40; t++) begin
      @(negedge clk);
      if (lead_stb) begin gap = t; break; end
    end
    check(gap == 4, "R7 new divisor after boundary", gap, 4);

    @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R8 stop clears outputs",
          {sclk, lead_stb, trail_stb}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule